// File: doc/BRIEF.md
# Expanding-Opcode Instruction Decoder

This block takes one 16-bit instruction word per qualified cycle and splits it into three things. The first is the instruction class, which is the number of address operands the word carries: three, two, one or none. The second is an operation number that counts from zero within that class. The third is the set of 4-bit operand fields the class carries. The opcode has no fixed length. When the leading nibble is all ones, it acts as an escape into a class with one operand fewer, and later all-ones nibbles escape further. The depth of the escape chain therefore sets both the operand count and where the operation number is read from. Every one of the 65536 possible words decodes into exactly one class.

The decode result is registered. It appears one cycle after a word is presented with the input strobe high, and an output valid flag marks it. Operand outputs that the decoded class does not use read as zero, and a presence mask reports which operand outputs carry data. The block performs no execution, fetch or memory access. It sits between an instruction source and whatever consumes the decoded fields.

Top module: `expop_decoder`

## Requirements
- R1: If bits [15:12] are not 1111, the class code is 0 (three operands). The operation number is bits [15:12] (0 to 14). Operand x is bits [11:8], y is bits [7:4], z is bits [3:0], and the mask is 111.
- R2: If bits [15:12] are 1111 and bits [11:8] are in 0000 to 1101, the class code is 1 (two operands). The operation number is bits [11:8] (0 to 13). Operand x is bits [7:4], y is bits [3:0], and the mask is 011.
- R3: If bits [15:8] are 11111110, the class code is 2 (one operand). The operation number is bits [7:4] (0 to 15), operand x is bits [3:0], and the mask is 001.
- R4: If bits [15:8] are 11111111 and bits [7:4] are in 0000 to 1110, the class code is 2. The operation number is bits [7:4] plus 16 (16 to 30), operand x is bits [3:0], and the mask is 001.
- R5: If bits [15:4] are all ones, the class code is 3 (no operands). The operation number is bits [3:0] (0 to 15), and the mask is 000.
- R6: Mask bit 0 flags operand x, bit 1 flags y and bit 2 flags z. Any operand output whose mask bit is clear reads as zero.
- R7: Every 16-bit word decodes to exactly one class. Over all 65536 words, the classes produce exactly 15, 14, 31 and 16 distinct operation numbers for class codes 0, 1, 2 and 3.
- R8: A word presented with the input strobe high at a rising edge appears on the outputs after that edge. The output valid flag equals the input strobe sampled at the previous edge.
- R9: While the input strobe is low, the decoded outputs keep their last values and the output valid flag is low after the next edge.
- R10: A synchronous active-high reset clears the output valid flag, class, operation number, operands and mask to zero, whatever the input strobe is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_word for this cycle |
| in_word | input | 16 | Instruction word to decode |
| out_valid | output | 1 | Decoded outputs hold a fresh result |
| out_class | output | 2 | 0 three-operand, 1 two-operand, 2 one-operand, 3 no-operand |
| out_op_idx | output | 5 | Operation number within the class |
| out_opnd_x | output | 4 | First operand field |
| out_opnd_y | output | 4 | Second operand field |
| out_opnd_z | output | 4 | Third operand field |
| out_opnd_mask | output | 3 | Presence mask, bit 0 x, bit 1 y, bit 2 z |

## Verification
The bench builds the decoder with its default 4-bit field width. That gives a 16-bit word, and the whole input space of 65536 words can be walked one word per cycle. The walk compares every word with a bench-side decode. It also counts distinct operation numbers per class, so a boundary slip at any escape nibble, such as 1101, 1110 or 1111 in the second or third nibble, changes a count or a single decode and is caught. A random phase with gaps in the strobe and a mid-stream reset then covers holding and clearing.

// File: rtl/expop_pkg.sv
package expop_pkg;

    // Field geometry: every field, opcode nibble or operand, has the same width.
    localparam int FIELD_W   = 4;
    localparam int N_FIELDS  = 4;
    localparam int N_OPND    = N_FIELDS - 1;
    localparam int WORD_W    = FIELD_W * N_FIELDS;
    localparam int IDX_W     = FIELD_W + 1;
    localparam int CLS_W     = 2;

    localparam logic [FIELD_W-1:0] FIELD_ONES = {FIELD_W{1'b1}};
    localparam logic [FIELD_W-1:0] FIELD_ESC1 = FIELD_ONES - 1'b1;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [WORD_W-1:0]  word_t;

    // Class code equals the escape depth, which is also the field that
    // carries the operation number.
    typedef enum logic [CLS_W-1:0] {
        CLS_ADDR3 = 2'd0,
        CLS_ADDR2 = 2'd1,
        CLS_ADDR1 = 2'd2,
        CLS_ADDR0 = 2'd3
    } iclass_e;

    typedef struct packed {
        iclass_e                      cls;
        logic [IDX_W-1:0]             idx;
        field_t [N_OPND-1:0]          opnd;   // [0]=x, [1]=y, [2]=z
        logic [N_OPND-1:0]            mask;
    } decode_t;

    // Number of operations each class encodes for the current field width.
    function automatic int unsigned ops_in_class(input logic [CLS_W-1:0] c);
        case (c)
            2'd0:    return (1 << FIELD_W) - 1;
            2'd1:    return (1 << FIELD_W) - 2;
            2'd2:    return (1 << (FIELD_W + 1)) - 1;
            default: return (1 << FIELD_W);
        endcase
    endfunction

    // Field k counted from the most significant end of the word.
    function automatic field_t field_at(input word_t w, input int k);
        return w[WORD_W-1-k*FIELD_W -: FIELD_W];
    endfunction

endpackage

// File: rtl/expop_field_split.sv
module expop_field_split
    import expop_pkg::*;
(
    input  word_t                 word,
    output field_t [N_FIELDS-1:0] fld,
    output logic   [N_FIELDS-2:0] is_ones,
    output logic                  f1_is_esc1
);

    // Fields are numbered from the top: fld[0] is the leading nibble.
    for (genvar k = 0; k < N_FIELDS; k++) begin : g_fld
        assign fld[k] = field_at(word, k);
    end

    // Escape flags are only needed for the fields that can extend the opcode.
    for (genvar k = 0; k < N_FIELDS - 1; k++) begin : g_ones
        assign is_ones[k] = &fld[k];
    end

    assign f1_is_esc1 = (fld[1] == FIELD_ESC1);

endmodule

// File: rtl/expop_class_sel.sv
module expop_class_sel
    import expop_pkg::*;
(
    input  logic [N_FIELDS-2:0] is_ones,
    input  logic                f1_is_esc1,
    output iclass_e             cls,
    output logic                grp_hi
);

    logic esc0, esc_one, esc_zero;

    always_comb begin
        esc0     = is_ones[0];
        esc_zero = esc0 && is_ones[1] && is_ones[2];
        esc_one  = esc0 && !esc_zero && (f1_is_esc1 || is_ones[1]);

        if (!esc0)         cls = CLS_ADDR3;
        else if (esc_zero) cls = CLS_ADDR0;
        else if (esc_one)  cls = CLS_ADDR1;
        else               cls = CLS_ADDR2;

        // Upper group of the one-operand class is reached through an
        // all-ones second field rather than the one-below-ones code.
        grp_hi = esc_one && is_ones[1];
    end

endmodule

// File: rtl/expop_operand_map.sv
module expop_operand_map
    import expop_pkg::*;
(
    input  field_t [N_FIELDS-1:0] fld,
    input  iclass_e               cls,
    input  logic                  grp_hi,
    output decode_t               dec
);

    logic [CLS_W-1:0] depth;
    assign depth = cls;

    // cand[s][d]: what operand slot s would carry at escape depth d.
    field_t [N_OPND-1:0][N_OPND-1:0] cand;
    field_t [N_OPND-1:0]             opnd;
    logic   [N_OPND-1:0]             mask;

    for (genvar s = 0; s < N_OPND; s++) begin : g_slot
        for (genvar d = 0; d < N_OPND; d++) begin : g_depth
            if (s + 1 + d < N_FIELDS) begin : g_src
                assign cand[s][d] = (depth == d) ? fld[s+1+d] : '0;
            end else begin : g_none
                assign cand[s][d] = '0;
            end
        end

        always_comb begin
            opnd[s] = '0;
            for (int d = 0; d < N_OPND; d++) begin
                opnd[s] = opnd[s] | cand[s][d];
            end
            mask[s] = (int'(depth) + s) < N_OPND;
        end
    end

    always_comb begin
        dec.cls  = cls;
        dec.idx  = {(cls == CLS_ADDR1) && grp_hi, fld[depth]};
        dec.opnd = opnd;
        dec.mask = mask;
    end

endmodule

// File: rtl/expop_out_stage.sv
module expop_out_stage
    import expop_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  decode_t d,
    output decode_t q,
    output logic    q_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/expop_decoder.sv
module expop_decoder
    import expop_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [WORD_W-1:0]          in_word,
    output logic                       out_valid,
    output logic [CLS_W-1:0]           out_class,
    output logic [IDX_W-1:0]           out_op_idx,
    output logic [FIELD_W-1:0]         out_opnd_x,
    output logic [FIELD_W-1:0]         out_opnd_y,
    output logic [FIELD_W-1:0]         out_opnd_z,
    output logic [N_OPND-1:0]          out_opnd_mask
);

    field_t [N_FIELDS-1:0] fld;
    logic   [N_FIELDS-2:0] is_ones;
    logic                  f1_is_esc1;
    iclass_e               cls;
    logic                  grp_hi;
    decode_t               dec_comb;
    decode_t               dec_q;

    expop_field_split u_split (
        .word       (in_word),
        .fld        (fld),
        .is_ones    (is_ones),
        .f1_is_esc1 (f1_is_esc1)
    );

    expop_class_sel u_class (
        .is_ones    (is_ones),
        .f1_is_esc1 (f1_is_esc1),
        .cls        (cls),
        .grp_hi     (grp_hi)
    );

    expop_operand_map u_map (
        .fld    (fld),
        .cls    (cls),
        .grp_hi (grp_hi),
        .dec    (dec_comb)
    );

    expop_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d        (dec_comb),
        .q        (dec_q),
        .q_valid  (out_valid)
    );

    assign out_class     = dec_q.cls;
    assign out_op_idx    = dec_q.idx;
    assign out_opnd_x    = dec_q.opnd[0];
    assign out_opnd_y    = dec_q.opnd[1];
    assign out_opnd_z    = dec_q.opnd[2];
    assign out_opnd_mask = dec_q.mask;

endmodule

// File: rtl/expop_decoder_chk.sv
module expop_decoder_chk
    import expop_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [WORD_W-1:0]    in_word,
    input logic                 out_valid,
    input logic [CLS_W-1:0]     out_class,
    input logic [IDX_W-1:0]     out_op_idx,
    input logic [FIELD_W-1:0]   out_opnd_x,
    input logic [FIELD_W-1:0]   out_opnd_y,
    input logic [FIELD_W-1:0]   out_opnd_z,
    input logic [N_OPND-1:0]    out_opnd_mask
);

    // R10: reset empties the output register whatever the strobe does.
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && out_class == '0 && out_op_idx == '0 &&
                 out_opnd_mask == '0));

    // R8: output valid tracks the strobe one edge later.
    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9: unqualified cycles leave the decoded outputs untouched.
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_class) && $stable(out_op_idx) &&
                       $stable(out_opnd_x) && $stable(out_opnd_y) &&
                       $stable(out_opnd_z) && $stable(out_opnd_mask)));

    // R6: mask population is tied to the escape depth.
    assert_mask_class_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_opnd_mask) == N_OPND - int'(out_class)));

    assert_unused_x_R6: assert property (@(posedge clk) disable iff (rst)
        !out_opnd_mask[0] |-> out_opnd_x == '0);
    assert_unused_y_R6: assert property (@(posedge clk) disable iff (rst)
        !out_opnd_mask[1] |-> out_opnd_y == '0);
    assert_unused_z_R6: assert property (@(posedge clk) disable iff (rst)
        !out_opnd_mask[2] |-> out_opnd_z == '0);

    // R7: operation numbers never exceed the per-class population.
    assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_op_idx) < int'(ops_in_class(out_class))));

    // R1: a leading nibble below all-ones selects the three-operand class.
    assert_addr3_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[15:12] != 4'hF) |=>
        (out_class == 2'd0 && out_op_idx == {1'b0, $past(in_word[15:12])} &&
         out_opnd_x == $past(in_word[11:8])));

    // R5: twelve leading ones select the no-operand class.
    assert_addr0_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (&in_word[15:4])) |=>
        (out_class == 2'd3 && out_op_idx == {1'b0, $past(in_word[3:0])}));

endmodule

bind expop_decoder expop_decoder_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_word       (in_word),
    .out_valid     (out_valid),
    .out_class     (out_class),
    .out_op_idx    (out_op_idx),
    .out_opnd_x    (out_opnd_x),
    .out_opnd_y    (out_opnd_y),
    .out_opnd_z    (out_opnd_z),
    .out_opnd_mask (out_opnd_mask)
);

// File: tb/tb_expop_decoder.sv
`timescale 1ns/1ps
module tb_expop_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        out_valid;
    logic [1:0]  out_class;
    logic [4:0]  out_op_idx;
    logic [3:0]  out_opnd_x, out_opnd_y, out_opnd_z;
    logic [2:0]  out_opnd_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // expected state of the output register
    logic        e_valid;
    logic [1:0]  e_cls;
    logic [4:0]  e_idx;
    logic [3:0]  e_x, e_y, e_z;
    logic [2:0]  e_mask;
    string       e_tag;

    logic [31:0] seen [4];

    always #2.5 clk = ~clk;

    expop_decoder dut (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_word       (in_word),
        .out_valid     (out_valid),
        .out_class     (out_class),
        .out_op_idx    (out_op_idx),
        .out_opnd_x    (out_opnd_x),
        .out_opnd_y    (out_opnd_y),
        .out_opnd_z    (out_opnd_z),
        .out_opnd_mask (out_opnd_mask)
    );

    // Bench-side decode written straight from R1..R5 and R6.
    task automatic ref_dec(input logic [15:0] w);
        e_x = 4'h0; e_y = 4'h0; e_z = 4'h0;
        if (w[15:12] != 4'hF) begin
            e_cls = 2'd0; e_idx = {1'b0, w[15:12]};
            e_x = w[11:8]; e_y = w[7:4]; e_z = w[3:0]; e_mask = 3'b111;
            e_tag = "R1";
        end else if (w[11:8] <= 4'hD) begin
            e_cls = 2'd1; e_idx = {1'b0, w[11:8]};
            e_x = w[7:4]; e_y = w[3:0]; e_mask = 3'b011;
            e_tag = "R2";
        end else if (w[11:8] == 4'hE) begin
            e_cls = 2'd2; e_idx = {1'b0, w[7:4]};
            e_x = w[3:0]; e_mask = 3'b001;
            e_tag = "R3";
        end else if (w[7:4] != 4'hF) begin
            e_cls = 2'd2; e_idx = 5'd16 + {1'b0, w[7:4]};
            e_x = w[3:0]; e_mask = 3'b001;
            e_tag = "R4";
        end else begin
            e_cls = 2'd3; e_idx = {1'b0, w[3:0]}; e_mask = 3'b000;
            e_tag = "R5";
        end
    endtask

    task automatic check_out();
        checks++;
        if (out_valid !== e_valid || out_class !== e_cls || out_op_idx !== e_idx ||
            out_opnd_x !== e_x || out_opnd_y !== e_y || out_opnd_z !== e_z ||
            out_opnd_mask !== e_mask) begin
            errors++;
            $display("FAIL %s word=%h: got v=%b cls=%0d idx=%0d x=%h y=%h z=%h m=%b, expected v=%b cls=%0d idx=%0d x=%h y=%h z=%h m=%b",
                     e_tag, in_word, out_valid, out_class, out_op_idx, out_opnd_x,
                     out_opnd_y, out_opnd_z, out_opnd_mask, e_valid, e_cls, e_idx,
                     e_x, e_y, e_z, e_mask);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next
    // falling edge (R8 latency, R9 hold when v is low).
    task automatic step(input logic v, input logic [15:0] w);
        in_valid = v;
        in_word  = w;
        if (v) begin
            ref_dec(w);
        end else begin
            e_tag = "R9";
        end
        e_valid = v;
        @(negedge clk);
        check_out();
        if (e_tag == "R9") begin
            // keep message meaningful for next qualified word
            e_tag = "R9";
        end
    endtask

    task automatic clear_expect();
        e_valid = 1'b0; e_cls = '0; e_idx = '0;
        e_x = '0; e_y = '0; e_z = '0; e_mask = '0;
        e_tag = "R10";
    endtask

    // R10: reset with the strobe held high still leaves everything cleared.
    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b1;
        in_word = 16'h1234;
        @(negedge clk);
        @(negedge clk);
        clear_expect();
        check_out();
        rst = 1'b0;
    endtask

    initial begin
        int cnt;
        logic [15:0] w;
        clear_expect();
        for (int c = 0; c < 4; c++) seen[c] = '0;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // Directed corners at each escape boundary.
        step(1'b1, 16'hEFFF);   // R1 top three-operand index 14
        step(1'b1, 16'h0A5C);   // R1
        step(1'b1, 16'hF000);   // R2 index 0
        step(1'b1, 16'hFD9A);   // R2 index 13
        step(1'b1, 16'hFE00);   // R3 index 0
        step(1'b1, 16'hFEF7);   // R3 index 15
        step(1'b1, 16'hFF03);   // R4 index 16
        step(1'b1, 16'hFFEB);   // R4 index 30
        step(1'b1, 16'hFFF0);   // R5 index 0
        step(1'b1, 16'hFFFF);   // R5 index 15
        step(1'b0, 16'h0123);   // R9 hold of the previous result
        step(1'b0, 16'hF000);   // R9

        // R7: exhaustive sweep, counting distinct operation numbers per class.
        for (int k = 0; k < 65536; k++) begin
            step(1'b1, k[15:0]);
            seen[out_class][out_op_idx] = 1'b1;
        end
        begin
            int exp_cnt [4];
            exp_cnt[0] = 15; exp_cnt[1] = 14; exp_cnt[2] = 31; exp_cnt[3] = 16;
            for (int c = 0; c < 4; c++) begin
                cnt = $countones(seen[c]);
                checks++;
                if (cnt != exp_cnt[c]) begin
                    errors++;
                    $display("FAIL R7 class %0d distinct ops: got %0d expected %0d",
                             c, cnt, exp_cnt[c]);
                end
            end
        end

        // Random mix of gaps and words biased toward escape prefixes (R8, R9).
        for (int k = 0; k < 4000; k++) begin
            w = 16'($urandom);
            case ($urandom % 4)
                0: w[15:12] = 4'hF;
                1: w[15:8]  = 8'hFE;
                2: w[15:8]  = 8'hFF;
                default: ;
            endcase
            if (($urandom % 16) == 0) w[15:4] = 12'hFFF;
            step(($urandom % 3) != 0, w);
            if (k == 2000) begin
                do_reset();   // R10 mid-stream
                step(1'b0, 16'hABCD);   // R9 after reset: cleared values held
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule